// File: doc/BRIEF.md
# Coherence Response Event Decoder with Pending-Ack Tracker

This block sits beside a cache-line controller that has one miss outstanding. Each cycle the controller may present one incoming coherence response: its kind, a flag saying whether a peer first-level cache sent it, a signed acknowledgement-count field, and the controller's current line-state code. The block turns that response into exactly one controller event. The event is registered, so it appears one cycle later as a one-hot vector qualified by a valid flag. A response kind the block does not know raises an error pulse instead of an event.

The block also holds the signed count of invalidation acknowledgements still owed to the miss. An allocate strobe clears the count to zero when a tracking entry is created. An update strobe subtracts the presented acknowledgement-count field from it. Data and acknowledgement responses count as final when the running count minus the message's field is zero. Data from a peer cache that arrives while the line waits on a shared miss skips the counting and gets its own event.

Response kind codes on `rsp_kind`: 0 exclusive data, 1 data, 2 acknowledgement, 3 writeback acknowledgement, 4 to 7 illegal. Event bits on `evt_onehot`: bit 0 exclusive data, bit 1 peer shared data, bit 2 data still awaiting acks, bit 3 data with all acks, bit 4 partial ack, bit 5 final ack, bit 6 writeback done. The decode is a unique case over the kind enumeration. Its transitions are XDATA→bit 0, DATA→bit 1/2/3, ACK→bit 4/5, WBDONE→bit 6, and default→error.

Top module: `resp_classifier`

## Requirements
- R1: While reset is held, and in the first cycle after it, `evt_valid`, `rsp_err` and `evt_onehot` are zero and `pending` is zero.
- R2: A valid response of kind 0 (exclusive data) yields event bit 0, whatever the line state, peer flag or counts.
- R3: A valid response of kind 1 (data) with `rsp_from_peer`=1 and `line_state` equal to 5 or 8 (the two shared-miss codes) yields event bit 1. This takes priority over ack counting.
- R4: Any other valid kind-1 response yields bit 3 when `pending` minus `rsp_ack_cnt`, compared as signed values, is zero, and bit 2 otherwise.
- R5: A valid kind-2 (acknowledgement) response yields bit 5 when signed `pending` minus `rsp_ack_cnt` is zero, and bit 4 otherwise.
- R6: A valid kind-3 response yields event bit 6.
- R7: A valid response of kind 4 to 7 gives `rsp_err`=1 for one cycle with `evt_valid`=0 and `evt_onehot`=0.
- R8: The outputs for a response appear exactly one cycle after `rsp_valid`. A cycle without `rsp_valid` gives `evt_valid`=0 and `rsp_err`=0 in the next cycle. When `evt_valid` is 1, exactly one event bit is set.
- R9: With `cnt_update`=1, `pending` becomes `pending - rsp_ack_cnt` (signed) the next cycle, and it may go negative. With neither strobe, `pending` holds.
- R10: With `trk_alloc`=1, `pending` becomes zero the next cycle, even if `cnt_update` is also high.
- R11: A response is classified against the value `pending` held before any update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsp_valid | input | 1 | A response is presented this cycle |
| rsp_kind | input | 3 | Response kind code |
| rsp_from_peer | input | 1 | Sender is a peer first-level cache |
| rsp_ack_cnt | input | CNT_W (6) | Signed acknowledgement-count field |
| line_state | input | ST_W (4) | Controller line-state code |
| trk_alloc | input | 1 | Clear pending count (tracking entry allocated) |
| cnt_update | input | 1 | Subtract `rsp_ack_cnt` from pending count |
| evt_valid | output | 1 | Registered event valid |
| evt_onehot | output | 7 | Registered one-hot event |
| pending | output | CNT_W (6) | Signed pending-ack count |
| rsp_err | output | 1 | Registered illegal-kind pulse |

## Verification
On every cycle the assertions check the shape of the outputs and the counter's arithmetic. They confirm that an event is one-hot and never coincides with an error, that nothing appears without a response a cycle earlier, that exclusive data and writeback kinds land on their fixed bits, that allocate clears and wins, and that an update subtracts the field exactly. The choice among data, final data and peer data, and between partial and final acknowledgements, depends on the running count and the line state. That choice, the signed zero test with negative counts, and the use of the pre-update count only show up in the bench scenarios, which compare each result with an independent model of the count.

// File: rtl/resp_cls_pkg.sv
package resp_cls_pkg;
    typedef enum logic [2:0] {
        RK_XDATA  = 3'd0,
        RK_DATA   = 3'd1,
        RK_ACK    = 3'd2,
        RK_WBDONE = 3'd3
    } rsp_kind_e;

    localparam int EV_N       = 7;
    localparam int EV_XDATA   = 0;
    localparam int EV_PEERSH  = 1;
    localparam int EV_DPART   = 2;
    localparam int EV_DFINAL  = 3;
    localparam int EV_APART   = 4;
    localparam int EV_AFINAL  = 5;
    localparam int EV_WBDONE  = 6;
endpackage

// File: rtl/rsp_decode.sv
module rsp_decode
    import resp_cls_pkg::*;
#(
    parameter int CNT_W = 6,
    parameter int ST_W  = 4,
    parameter logic [ST_W-1:0] SHM_A = 4'd5,
    parameter logic [ST_W-1:0] SHM_B = 4'd8
) (
    input  logic [2:0]              kind,
    input  logic                    from_peer,
    input  logic [ST_W-1:0]         lstate,
    input  logic signed [CNT_W-1:0] pend,
    input  logic signed [CNT_W-1:0] ack,
    output logic [EV_N-1:0]         ev,
    output logic                    bad
);
    localparam int DW = CNT_W + 1;

    logic signed [DW-1:0] diff;
    logic                 last;
    logic                 shared_miss;

    always_comb begin
        diff        = DW'(pend) - DW'(ack);
        last        = (diff == '0);
        shared_miss = (lstate == SHM_A) || (lstate == SHM_B);
    end

    always_comb begin
        ev  = '0;
        bad = 1'b0;
        unique case (kind)
            RK_XDATA:  ev[EV_XDATA] = 1'b1;
            RK_DATA: begin
                if (from_peer && shared_miss) ev[EV_PEERSH] = 1'b1;
                else if (last)                ev[EV_DFINAL] = 1'b1;
                else                          ev[EV_DPART]  = 1'b1;
            end
            RK_ACK: begin
                if (last) ev[EV_AFINAL] = 1'b1;
                else      ev[EV_APART]  = 1'b1;
            end
            RK_WBDONE: ev[EV_WBDONE] = 1'b1;
            default:   bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/ack_counter.sv
module ack_counter #(
    parameter int CNT_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    upd,
    input  logic signed [CNT_W-1:0] ack,
    output logic signed [CNT_W-1:0] pend
);
    always_ff @(posedge clk) begin
        if (!rst_n)   pend <= '0;
        else if (clr) pend <= '0;
        else if (upd) pend <= pend - ack;
    end

    assert_alloc_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> pend == '0);
    assert_update_subtracts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(upd) && !$past(clr)) |-> pend == CNT_W'($past(pend) - $past(ack)));
    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(upd) && !$past(clr)) |-> $stable(pend));
endmodule

// File: rtl/resp_classifier.sv
module resp_classifier
    import resp_cls_pkg::*;
#(
    parameter int CNT_W = 6,
    parameter int ST_W  = 4,
    parameter logic [ST_W-1:0] SHM_A = 4'd5,
    parameter logic [ST_W-1:0] SHM_B = 4'd8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rsp_valid,
    input  logic [2:0]              rsp_kind,
    input  logic                    rsp_from_peer,
    input  logic signed [CNT_W-1:0] rsp_ack_cnt,
    input  logic [ST_W-1:0]         line_state,
    input  logic                    trk_alloc,
    input  logic                    cnt_update,
    output logic                    evt_valid,
    output logic [EV_N-1:0]         evt_onehot,
    output logic signed [CNT_W-1:0] pending,
    output logic                    rsp_err
);
    logic [EV_N-1:0] ev_next;
    logic            bad_next;

    rsp_decode #(.CNT_W(CNT_W), .ST_W(ST_W), .SHM_A(SHM_A), .SHM_B(SHM_B)) u_dec (
        .kind      (rsp_kind),
        .from_peer (rsp_from_peer),
        .lstate    (line_state),
        .pend      (pending),
        .ack       (rsp_ack_cnt),
        .ev        (ev_next),
        .bad       (bad_next)
    );

    ack_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (trk_alloc),
        .upd   (cnt_update),
        .ack   (rsp_ack_cnt),
        .pend  (pending)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid  <= 1'b0;
            evt_onehot <= '0;
            rsp_err    <= 1'b0;
        end else begin
            evt_valid  <= rsp_valid && !bad_next;
            evt_onehot <= (rsp_valid && !bad_next) ? ev_next : '0;
            rsp_err    <= rsp_valid && bad_next;
        end
    end

    assert_event_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> $countones(evt_onehot) == 1);
    assert_err_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (!evt_valid && evt_onehot == '0));
    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rsp_valid) |-> (!evt_valid && !rsp_err));
    assert_xdata_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 3'd0) |=> (evt_valid && evt_onehot[EV_XDATA]));
    assert_wbdone_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 3'd3) |=> (evt_valid && evt_onehot[EV_WBDONE]));
    assert_illegal_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind[2]) |=> rsp_err);
endmodule

// File: tb/resp_classifier_test.sv
module resp_classifier_test;
    localparam int CNT_W = 6;

    logic clk = 1'b0;
    logic rst_n;
    logic rsp_valid, rsp_from_peer, trk_alloc, cnt_update;
    logic [2:0] rsp_kind;
    logic signed [CNT_W-1:0] rsp_ack_cnt;
    logic [3:0] line_state;
    logic evt_valid, rsp_err;
    logic [6:0] evt_onehot;
    logic signed [CNT_W-1:0] pending;

    int n_tests = 0;
    int n_fail  = 0;
    int m_pend  = 0;
    int unsigned seed_v;

    always #2 clk = ~clk;

    resp_classifier uut (
        .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
        .rsp_from_peer(rsp_from_peer), .rsp_ack_cnt(rsp_ack_cnt),
        .line_state(line_state), .trk_alloc(trk_alloc), .cnt_update(cnt_update),
        .evt_valid(evt_valid), .evt_onehot(evt_onehot), .pending(pending),
        .rsp_err(rsp_err)
    );

    // returns {err, event[6:0]}
    function automatic logic [7:0] exp_fn(input int k, input bit peer,
                                          input int st, input int pend, input int ack);
        logic [7:0] r = '0;
        case (k)
            0: r[0] = 1'b1;
            1: if (peer && (st == 5 || st == 8)) r[1] = 1'b1;
               else if (pend - ack == 0)          r[3] = 1'b1;
               else                               r[2] = 1'b1;
            2: if (pend - ack == 0) r[5] = 1'b1; else r[4] = 1'b1;
            3: r[6] = 1'b1;
            default: r[7] = 1'b1;
        endcase
        return r;
    endfunction

    function automatic string req_of(input int k, input bit peer, input int st);
        case (k)
            0: return "R2";
            1: return (peer && (st == 5 || st == 8)) ? "R3" : "R4";
            2: return "R5";
            3: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // called at a falling edge; drives one cycle and checks at the next falling edge
    task automatic apply(input bit v, input int k, input bit peer, input int st,
                         input int ack, input bit upd, input bit alloc);
        logic [7:0] e;
        int new_pend;
        e = exp_fn(k, peer, st, m_pend, ack);
        new_pend = alloc ? 0 : (upd ? m_pend - ack : m_pend);
        rsp_valid = v; rsp_kind = 3'(k); rsp_from_peer = peer;
        line_state = 4'(st); rsp_ack_cnt = CNT_W'(ack);
        cnt_update = upd; trk_alloc = alloc;
        @(negedge clk);
        if (v) begin
            chk(evt_valid == !e[7], req_of(k, peer, st), int'(evt_valid), int'(!e[7]));
            chk(evt_onehot == e[6:0], req_of(k, peer, st), int'(evt_onehot), int'(e[6:0]));
            chk(rsp_err == e[7], "R7", int'(rsp_err), int'(e[7]));
        end else begin
            chk(!evt_valid && !rsp_err, "R8", int'({evt_valid, rsp_err}), 0);
        end
        chk(int'(pending) == new_pend, alloc ? "R10" : "R9", int'(pending), new_pend);
        m_pend = new_pend;
        rsp_valid = 0; cnt_update = 0; trk_alloc = 0;
    endtask

    initial begin
        #300000;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        seed_v = 32'd1234;
        void'($urandom(seed_v));
        rst_n = 0; rsp_valid = 0; rsp_kind = 0; rsp_from_peer = 0;
        rsp_ack_cnt = 0; line_state = 0; trk_alloc = 0; cnt_update = 0;
        repeat (3) @(negedge clk);
        chk(!evt_valid && !rsp_err && evt_onehot == 0 && pending == 0, "R1",
            int'({evt_valid, rsp_err, evt_onehot}), 0);
        rst_n = 1;
        @(negedge clk);
        chk(!evt_valid && pending == 0, "R1", int'(pending), 0);

        // directed corner cases
        apply(1, 0, 1, 5, 3, 0, 1);     // R2 exclusive data, alloc clears
        apply(0, 2, 0, 0, 1, 1, 0);     // R9 ack pulls pending to -1
        apply(0, 2, 0, 0, 1, 1, 0);     // R9 pending -2
        apply(1, 1, 0, 2, -2, 1, 0);    // R4 data final with negative count
        apply(1, 1, 1, 8, 0, 0, 0);     // R3 peer data, pending 0, priority
        apply(1, 1, 1, 3, 0, 0, 0);     // R4 peer but not shared-miss -> final
        apply(1, 1, 0, 2, 2, 1, 0);     // R4 data partial, R11 pre-update count
        apply(1, 2, 0, 0, 1, 1, 0);     // R5 ack partial (-2 -1 != 0)
        apply(1, 2, 0, 0, -3, 1, 0);    // R5 ack final, R11
        apply(1, 3, 0, 0, 0, 1, 1);     // R6 + R10 alloc wins over update
        apply(1, 5, 0, 0, 0, 0, 0);     // R7 illegal kind
        apply(1, 7, 1, 5, 0, 0, 0);     // R7 illegal kind
        apply(0, 1, 1, 5, 0, 0, 0);     // R8 no valid, no event

        // constrained random
        for (int i = 0; i < 2000; i++) begin
            int k, st, ack;
            bit v, peer, upd, alloc;
            v     = ($urandom_range(0, 3) != 0);
            k     = ($urandom_range(0, 9) == 0) ? $urandom_range(4, 7) : $urandom_range(0, 3);
            peer  = $urandom_range(0, 1);
            st    = $urandom_range(0, 15);
            ack   = $urandom_range(0, 6) - 3;
            upd   = $urandom_range(0, 1);
            alloc = ($urandom_range(0, 5) == 0) || (m_pend > 20) || (m_pend < -20);
            if ($urandom_range(0, 2) == 0) ack = m_pend;   // exercise final events
            if (ack > 31 || ack < -32) ack = 0;
            apply(v, k, peer, st, ack, upd, alloc);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule